// File: doc/BRIEF.md
# Serial CRC-8 Generator and Checker for Single-Wire Device IDs

This block computes an 8-bit cyclic redundancy check one bit at a time. It is meant for a single-wire bus controller that has to both produce and verify the check byte of a 64-bit device identity and of ordinary data streams. The generator polynomial is x^8 + x^5 + x^4 + 1, used in bit-reversed form, and bits are fed least significant bit first. A clear empties the register before each message. After a 56-bit body has passed through, the register holds the check byte. Passing that byte through as well returns the register to zero.

The block has two ways to feed it. In bit mode the caller presents one bit with a shift strobe. In identity mode the caller hands over a whole 64-bit value with a load strobe. The block then sends that value out on a serial output, lowest bit first, one bit per cycle, and folds each bit into the CRC as it goes. In both modes the block counts shifts since the last clear. A zero-residue flag reports a good identity only when exactly 64 bits have gone in and the register is zero. A second flag also requires the first byte to equal the expected family code.

Top module: `crc8_serial_unit`

## Requirements
- R1: After reset, `crcOut` is 0x00, and `residueOk`, `idValid`, `romBitValid` and `romDone` are all low.
- R2: A shift updates `crcOut` on the next clock edge. The update takes fb = crcOut[0] XOR bit, shifts the register right by one with a zero entering bit 7, then XORs fb into bits 7, 3 and 2 (mask 0x8C).
- R3: While there is no shift, clear or load, `crcOut` keeps its value, whatever `bitIn` does.
- R4: `clear` sets `crcOut` to zero and the shift count to zero on the next edge. When `clear` and `shiftEn` are high in the same cycle, the clear wins and the bit is discarded.
- R5: `residueOk` is high only when exactly 64 shifts have happened since the last clear or load and `crcOut` is zero. It is low after 63 shifts and after 65 shifts.
- R6: `idValid` is high only when `residueOk` is high and the first eight bits shifted in, read least significant bit first, form the value 0x42.
- R7: When `romLoad` is high and no stream is running, the CRC and the shift count are cleared. Starting in the following cycle, `romBit` presents `romValue` bit 0, then bit 1 and so on, one bit per cycle. `romBitValid` stays high for exactly 64 cycles.
- R8: Each streamed bit is folded into the CRC. `romDone` is high for one cycle, in the cycle after the last streamed bit. At that point `crcOut`, `residueOk` and `idValid` reflect all 64 bits.
- R9: While a stream is running, `shiftEn`, `bitIn` and a new `romLoad` have no effect on the streamed bits or on the final CRC.
- R10: `clear` during a stream ends it. In the next cycle `romBitValid` is low and `crcOut` is zero, and no `romDone` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Clears the CRC and the shift count; aborts a stream |
| shiftEn | input | 1 | Shift strobe for bit mode |
| bitIn | input | 1 | Bit to fold in when `shiftEn` is high |
| romLoad | input | 1 | Starts streaming `romValue` |
| romValue | input | 64 | Identity value to stream, least significant bit first |
| crcOut | output | 8 | Running CRC register |
| residueOk | output | 1 | Exactly 64 shifts and a zero register |
| idValid | output | 1 | `residueOk` and first byte equal to the family code |
| romBit | output | 1 | Current streamed bit |
| romBitValid | output | 1 | `romBit` carries a stream bit this cycle |
| romDone | output | 1 | One-cycle pulse after the last streamed bit |

## Verification
The bench builds the block with its defaults: a 64-bit identity, an 8-bit register, the normal-form polynomial 0x31 and family code 0x42. With these values, identities built by the bench from its own 56-bit bodies and check bytes can be run through both feed paths. The 63- and 65-shift edges of the residue window, a good check byte behind a wrong family code, and the clear-versus-shift priority all become reachable with short directed sequences. A scoreboard queue holds the expected serial bits and end-of-stream results. This lets stream order, stalls caused by ignored inputs, and aborted streams show up as miscompares.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic clearAll;  // zero CRC, shift count and family capture
    logic loadRom;   // capture a new identity into the stream shifter
    logic shiftOn;   // fold one bit into the CRC this cycle
    logic useRom;    // bit source is the stream shifter, not bitIn
  } crcStrobe_t;

  // Bit-reverse the low w bits of a normal-form polynomial
  function automatic logic [31:0] reflectPoly(input logic [31:0] poly, input int w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < w; i++) begin
      r[w-1-i] = poly[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/crc8_ctrl.sv
module crc8_ctrl
  import crc8_pkg::*;
#(
  parameter int ID_BITS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       shiftEn,
  input  logic       romLoad,
  output crcStrobe_t strobe,
  output logic       busy,
  output logic       romDone
);

  localparam int REM_W = $clog2(ID_BITS + 1);
  localparam logic [REM_W-1:0] REM_FULL = REM_W'(ID_BITS);
  localparam logic [REM_W-1:0] REM_LAST = REM_W'(1);

  logic [REM_W-1:0] remain;
  logic             loadGo;

  // A load is only taken when idle and not overridden by clear
  assign loadGo = romLoad && !busy && !clear;

  always_comb begin
    strobe.clearAll = clear || loadGo;
    strobe.loadRom  = loadGo;
    strobe.useRom   = busy;
    strobe.shiftOn  = !clear && !loadGo && (busy || shiftEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      remain  <= '0;
      romDone <= 1'b0;
    end else if (clear) begin
      busy    <= 1'b0;
      remain  <= '0;
      romDone <= 1'b0;
    end else if (loadGo) begin
      busy    <= 1'b1;
      remain  <= REM_FULL;
      romDone <= 1'b0;
    end else if (busy) begin
      remain <= remain - 1'b1;
      if (remain == REM_LAST) begin
        busy    <= 1'b0;
        romDone <= 1'b1;
      end else begin
        romDone <= 1'b0;
      end
    end else begin
      romDone <= 1'b0;
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRom |=> busy) else $error("load did not start stream"); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    romDone |=> !romDone) else $error("done held longer than one cycle"); // R8

  AST_ABORT_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    (busy && clear) |=> (!busy && !romDone)) else $error("clear did not abort"); // R10

endmodule

// File: rtl/crc8_datapath.sv
module crc8_datapath
  import crc8_pkg::*;
#(
  parameter int          ID_BITS     = 64,
  parameter int          CRC_W       = 8,
  parameter logic [31:0] POLY_NORMAL = 32'h31,
  parameter int          FAMILY_W    = 8,
  parameter logic [31:0] FAMILY_CODE = 32'h42
) (
  input  logic               clk,
  input  logic               rstN,
  input  crcStrobe_t         strobe,
  input  logic               bitIn,
  input  logic [ID_BITS-1:0] romValue,
  output logic [CRC_W-1:0]   crcReg,
  output logic               romBit,
  output logic               residueOk,
  output logic               idValid
);

  localparam int CNT_W = $clog2(ID_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ID_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(ID_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FAM  = CNT_W'(FAMILY_W);
  localparam logic [31:0] POLY_REFL_W = reflectPoly(POLY_NORMAL, CRC_W);
  localparam logic [CRC_W-1:0] POLY_REFL = POLY_REFL_W[CRC_W-1:0];
  localparam logic [FAMILY_W-1:0] FAMILY = FAMILY_CODE[FAMILY_W-1:0];

  logic [ID_BITS-1:0]  romShift;
  logic [CNT_W-1:0]    shiftCount;
  logic [FAMILY_W-1:0] famReg;
  logic [CRC_W-1:0]    crcNext;
  logic                dataBit;
  logic                feedback;

  assign dataBit  = strobe.useRom ? romShift[0] : bitIn;
  assign feedback = crcReg[0] ^ dataBit;
  assign romBit   = romShift[0];

  // Reflected LFSR: right shift, feedback XOR at the polynomial taps
  generate
    for (genvar i = 0; i < CRC_W; i++) begin : g_crcBit
      if (i == CRC_W - 1) begin : g_top
        assign crcNext[i] = feedback & POLY_REFL[i];
      end else begin : g_mid
        assign crcNext[i] = crcReg[i+1] ^ (feedback & POLY_REFL[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '0;
    end else if (strobe.clearAll) begin
      crcReg <= '0;
    end else if (strobe.shiftOn) begin
      crcReg <= crcNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCount <= '0;
    end else if (strobe.clearAll) begin
      shiftCount <= '0;
    end else if (strobe.shiftOn && shiftCount != CNT_SAT) begin
      shiftCount <= shiftCount + 1'b1;
    end
  end

  // Capture the leading family byte, least significant bit first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      famReg <= '0;
    end else if (strobe.clearAll) begin
      famReg <= '0;
    end else if (strobe.shiftOn && shiftCount < CNT_FAM) begin
      famReg <= {dataBit, famReg[FAMILY_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romShift <= '0;
    end else if (strobe.loadRom) begin
      romShift <= romValue;
    end else if (strobe.shiftOn && strobe.useRom) begin
      romShift <= {1'b0, romShift[ID_BITS-1:1]};
    end
  end

  assign residueOk = (shiftCount == CNT_FULL) && (crcReg == '0);
  assign idValid   = residueOk && (famReg == FAMILY);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (crcReg == '0)) else $error("clear left CRC nonzero"); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.shiftOn && !strobe.clearAll) |=> $stable(crcReg)) else $error("CRC moved without shift"); // R3

endmodule

// File: rtl/crc8_serial_unit.sv
module crc8_serial_unit
  import crc8_pkg::*;
#(
  parameter int          ID_BITS     = 64,
  parameter int          CRC_W       = 8,
  parameter logic [31:0] POLY_NORMAL = 32'h31,
  parameter int          FAMILY_W    = 8,
  parameter logic [31:0] FAMILY_CODE = 32'h42
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               shiftEn,
  input  logic               bitIn,
  input  logic               romLoad,
  input  logic [ID_BITS-1:0] romValue,
  output logic [CRC_W-1:0]   crcOut,
  output logic               residueOk,
  output logic               idValid,
  output logic               romBit,
  output logic               romBitValid,
  output logic               romDone
);

  crcStrobe_t strobe;
  logic       busy;

  crc8_ctrl #(
    .ID_BITS(ID_BITS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (clear),
    .shiftEn (shiftEn),
    .romLoad (romLoad),
    .strobe  (strobe),
    .busy    (busy),
    .romDone (romDone)
  );

  crc8_datapath #(
    .ID_BITS     (ID_BITS),
    .CRC_W       (CRC_W),
    .POLY_NORMAL (POLY_NORMAL),
    .FAMILY_W    (FAMILY_W),
    .FAMILY_CODE (FAMILY_CODE)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bitIn     (bitIn),
    .romValue  (romValue),
    .crcReg    (crcOut),
    .romBit    (romBit),
    .residueOk (residueOk),
    .idValid   (idValid)
  );

  assign romBitValid = busy;

  AST_DONE_AFTER_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    romDone |-> !romBitValid) else $error("done while streaming"); // R8

endmodule

// File: tb/tb_crc8_serial_unit.sv
module tb_crc8_serial_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        shiftEn = 1'b0;
  logic        bitIn = 1'b0;
  logic        romLoad = 1'b0;
  logic [63:0] romValue = '0;
  logic [7:0]  crcOut;
  logic        residueOk, idValid, romBit, romBitValid, romDone;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] model = '0;

  typedef struct packed { logic [7:0] crc; logic res; logic idv; } doneItem_t;
  logic      bitQ[$];
  doneItem_t doneQ[$];

  always #2.5 clk = ~clk;

  crc8_serial_unit dut (
    .clk(clk), .rstN(rstN), .clear(clear), .shiftEn(shiftEn), .bitIn(bitIn),
    .romLoad(romLoad), .romValue(romValue), .crcOut(crcOut), .residueOk(residueOk),
    .idValid(idValid), .romBit(romBit), .romBitValid(romBitValid), .romDone(romDone)
  );

  function automatic logic [7:0] step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    c = c >> 1;
    if (fb) c = c ^ 8'h8C;
    return c;
  endfunction

  function automatic logic [7:0] crcOf(input logic [63:0] v, input int n);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < n; i++) c = step(c, v[i]);
    return c;
  endfunction

  function automatic logic [63:0] makeId(input logic [7:0] fam, input logic [47:0] ser);
    logic [55:0] body;
    body = {ser, fam};
    return {crcOf({8'h00, body}, 56), body};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic feedBit(input logic b);
    shiftEn = 1'b1; bitIn = b;
    @(negedge clk);
    shiftEn = 1'b0;
    model = step(model, b);
  endtask

  task automatic doClear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model = '0;
  endtask

  task automatic feedBits(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) feedBit(v[i]);
  endtask

  // Driver: push expected stream bits and end result, then launch the stream
  task automatic streamId(input logic [63:0] v, input logic idvExp, input logic noisy);
    doneItem_t it;
    for (int i = 0; i < 64; i++) bitQ.push_back(v[i]);
    it.crc = crcOf(v, 64);
    it.res = (it.crc == 8'h00);
    it.idv = it.res && (v[7:0] == 8'h42) && idvExp;
    doneQ.push_back(it);
    romValue = v; romLoad = 1'b1;
    @(negedge clk);
    romLoad = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (noisy) begin
        shiftEn = i[0]; bitIn = i[1];
        romLoad = (i == 5); romValue = ~v;
      end
      @(negedge clk);
    end
    shiftEn = 1'b0; romLoad = 1'b0;
    @(negedge clk);
    check("R7 queue drained", bitQ.size(), 0);
    check("R8 done consumed", doneQ.size(), 0);
  endtask

  // Monitor: compare stream bits and end-of-stream results as they appear
  always @(negedge clk) begin
    if (rstN && romBitValid) begin
      if (bitQ.size() == 0) check("R7 unexpected bit", 1, 0);
      else check("R7 stream bit", romBit, bitQ.pop_front());
    end
    if (rstN && romDone) begin
      if (doneQ.size() == 0) check("R10 unexpected done", 1, 0);
      else begin
        doneItem_t it;
        it = doneQ.pop_front();
        check("R8 final crc", crcOut, it.crc);
        check("R5 residue after stream", residueOk, it.res);
        check("R6 family after stream", idValid, it.idv);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] goodId, badFam;
    goodId = makeId(8'h42, 48'h0000_A1B2_C3D4);
    badFam = makeId(8'h28, 48'h0012_3456_789A);

    repeat (3) @(negedge clk);
    check("R1 crc reset", crcOut, 8'h00);
    check("R1 residue reset", residueOk, 0);
    check("R1 idValid reset", idValid, 0);
    check("R1 stream idle", {romBitValid, romDone}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: single-bit updates against the model
    feedBit(1'b1);
    check("R2 first bit", crcOut, 8'h8C);
    feedBits(64'hDEAD_BEEF_0123_4567, 40);
    check("R2 many bits", crcOut, model);

    // R3: hold with bitIn toggling
    for (int i = 0; i < 4; i++) begin
      bitIn = i[0];
      @(negedge clk);
      check("R3 hold", crcOut, model);
    end

    // R4: clear beats simultaneous shift
    clear = 1'b1; shiftEn = 1'b1; bitIn = 1'b1;
    @(negedge clk);
    clear = 1'b0; shiftEn = 1'b0; model = '0;
    check("R4 clear wins", crcOut, 8'h00);

    // R5/R6: full valid ID through bit mode, count restarted by clear
    feedBits(goodId, 64);
    check("R5 residue at 64", residueOk, 1);
    check("R6 family match", idValid, 1);
    check("R2 zero residue", crcOut, 8'h00);
    feedBit(1'b0);
    check("R5 residue at 65", residueOk, 0);

    doClear();
    feedBits(goodId, 63);
    check("R5 residue at 63", residueOk, 0);

    doClear();
    feedBits(badFam, 64);
    check("R5 residue wrong family", residueOk, 1);
    check("R6 wrong family", idValid, 0);

    // R7/R8: streamed identities
    streamId(goodId, 1'b1, 1'b0);
    streamId(badFam, 1'b1, 1'b0);
    streamId(64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);

    // R9: noise on the bit path and a second load during the stream
    streamId(goodId, 1'b1, 1'b1);

    // R10: abort after ten bits
    for (int i = 0; i < 10; i++) bitQ.push_back(goodId[i]);
    romValue = goodId; romLoad = 1'b1;
    @(negedge clk);
    romLoad = 1'b0;
    repeat (9) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R10 stream stopped", romBitValid, 0);
    check("R10 crc cleared", crcOut, 8'h00);
    repeat (70) @(negedge clk);
    check("R10 no done", doneQ.size(), 0);
    check("R10 bits consumed", bitQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule